// File: doc/BRIEF.md
# Serial Three-Sample Odd-Parity Detector

This block watches a single-bit serial level coming from a two-throw mechanical contact. It splits the consumed samples into non-overlapping groups of three. When a group holds an odd number of ones (one or three, in any order), it pulls an active-low detect output low. The detect is a Mealy output. It depends on the current state and on the third sample, and it is gated so that it can only be low during the low phase of the clock.

The contact first passes through a set/reset hold cell driven by its normally-open and normally-closed throws. Contact bounce on one throw, which leaves both throws open for a time, therefore cannot change the level. The held level is then retimed by a synchronizer on the falling clock edge. The state machine advances on the rising edge. This gives a half-cycle window in which the synchronized sample and the Mealy output are both stable.

Top module: `odd3_detector`

## Requirements
- R1: While `rst_ni` is low, `detect_no_o` is high. The debounce cell, the synchronizer and the state machine return to their initial values: level 0 and the idle state, encoded 000. A group that was partly collected when reset arrived is discarded. After release, the next group starts from the idle state.
- R2: The debounce cell sets to 1 at a falling clock edge when `throw_no_i`=1 and `throw_nc_i`=0. It clears to 0 when `throw_nc_i`=1 and `throw_no_i`=0. It holds its value when both throws are open (0,0) or both are closed (1,1).
- R3: The debounced level passes through SYNC_STAGES falling-edge flops (default 1) before the state machine sees it. With the default setting, a throw change made during the high phase is consumed at the second rising edge after it.
- R4: The state machine takes one sample at every rising edge after reset. It groups the samples into non-overlapping triples, and it returns to idle after it takes the third sample of each triple.
- R5: `detect_no_o` is low during the low phase that ends with the rising edge taking the third sample of a group, exactly when the three samples hold an odd number of ones. This covers all eight three-bit patterns.
- R6: `detect_no_o` is high throughout every high phase of the clock, and throughout the low phases that precede the first or second sample of a group.
- R7: Consecutive groups are evaluated independently: the parity of one group has no effect on the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state on rising edge, synchronizer on falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| throw_no_i | input | 1 | Normally-open contact throw, 1 when closed |
| throw_nc_i | input | 1 | Normally-closed contact throw, 1 when closed |
| detect_no_o | output | 1 | Active-low odd-parity detect, valid in clock low phase |

## Verification
The assertions check the cycle-level rules on every edge. The debounce cell sets and holds as its throws dictate, the first sample of a group seeds the parity bit and moves the count to one, and each third sample sends the machine back to idle. Whether the detect pulse lands in the right half-cycle, and whether it matches the parity of all eight patterns, can only be shown by the bench. The bench also shows the end-to-end latency through the debounce and synchronizer stages, the alignment of groups after a mid-group reset, and bounce sequences with both throws open or both closed.

// File: rtl/odd3_pkg.sv
package odd3_pkg;
  // bits [2:1]: samples taken in group, bit 0: running parity
  typedef enum logic [2:0] {
    ST_IDLE  = 3'b000,
    ST_EVEN1 = 3'b010,
    ST_ODD1  = 3'b011,
    ST_EVEN2 = 3'b100,
    ST_ODD2  = 3'b101
  } odd3_state_e;
endpackage

// File: rtl/odd3_debounce.sv
module odd3_debounce (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic throw_no_i,
  input  logic throw_nc_i,
  output logic level_o
);
  logic set_w, clr_w, level_q;

  assign set_w = throw_no_i & ~throw_nc_i;
  assign clr_w = throw_nc_i & ~throw_no_i;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    level_q <= 1'b0;
    else if (set_w) level_q <= 1'b1;
    else if (clr_w) level_q <= 1'b0;
  end

  assign level_o = level_q;

  a_r2_hold_on_bounce: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (throw_no_i == throw_nc_i) |=> $stable(level_o));
  a_r2_set_on_no: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (throw_no_i && !throw_nc_i) |=> level_o);
  a_r2_clear_on_nc: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (throw_nc_i && !throw_no_i) |=> !level_o);
endmodule

// File: rtl/odd3_sync.sv
module odd3_sync #(
  parameter int unsigned STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/odd3_fsm.sv
module odd3_fsm
  import odd3_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  output logic fire_o
);
  odd3_state_e state_q, state_d;

  always_comb begin
    unique case (state_q)
      ST_IDLE:  state_d = sample_i ? ST_ODD1  : ST_EVEN1;
      ST_EVEN1: state_d = sample_i ? ST_ODD2  : ST_EVEN2;
      ST_ODD1:  state_d = sample_i ? ST_EVEN2 : ST_ODD2;
      default:  state_d = ST_IDLE;  // third sample or unused code
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // Mealy: odd total once the third sample is folded in
  assign fire_o = state_q[2] & (state_q[0] ^ sample_i);

  a_r4_group_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q[2] |=> (state_q == ST_IDLE));
  a_r4_first_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> (state_q[2:1] == 2'b01 && state_q[0] == $past(sample_i)));
endmodule

// File: rtl/odd3_detector.sv
module odd3_detector #(
  parameter int unsigned SYNC_STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic throw_no_i,
  input  logic throw_nc_i,
  output logic detect_no_o
);
  logic level_w, sample_w, fire_w;

  odd3_debounce u_debounce (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .throw_no_i (throw_no_i),
    .throw_nc_i (throw_nc_i),
    .level_o    (level_w)
  );

  odd3_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (level_w),
    .q_o    (sample_w)
  );

  odd3_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample_w),
    .fire_o   (fire_w)
  );

  // qualify with the low phase, where sample and state are both settled
  assign detect_no_o = ~(fire_w & ~clk_i & rst_ni);
endmodule

// File: tb/odd3_detector_test.sv
module odd3_detector_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic throw_no_i = 1'b0;
  logic throw_nc_i = 1'b1;
  logic detect_no_o;

  localparam logic [1:0] C_OPEN = 2'b00, C_CLR = 2'b01, C_SET = 2'b10, C_BOTH = 2'b11;
  // [3:1] samples in order (first at bit 3), [0] odd flag
  localparam logic [3:0] VEC [8] = '{
    4'b000_0, 4'b001_1, 4'b010_1, 4'b011_0,
    4'b100_1, 4'b101_0, 4'b110_0, 4'b111_1};

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [1:0] codes [64];
  logic deb [64];
  int ncodes;

  odd3_detector uut (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: detect_no_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic cons(int k);
    return (k >= 2) ? deb[k-2] : 1'b0;
  endfunction

  task automatic run_stream(int first_tab_group, int tab_groups);
    logic d = 1'b0;
    for (int i = 0; i < 64; i++) begin
      logic [1:0] c = (i < ncodes) ? codes[i] : C_OPEN;
      if (c == C_SET) d = 1'b1;
      else if (c == C_CLR) d = 1'b0;
      deb[i] = d;
    end
    for (int j = 0; j < ncodes + 3; j++) begin
      @(posedge clk_i);
      #1;
      {throw_no_i, throw_nc_i} = (j < ncodes) ? codes[j] : C_OPEN;
      #1;
      check("R6 high phase", detect_no_o, 1'b1);
      @(negedge clk_i);
      #2;
      begin
        int k = j + 1;
        int g = k / 3;
        logic exp = 1'b1;
        if (k % 3 == 2) begin
          exp = ~(cons(k-2) ^ cons(k-1) ^ cons(k));
          if (g >= first_tab_group && g < first_tab_group + tab_groups)
            check("R5 pattern table", detect_no_o, ~VEC[g-first_tab_group][0]);
          else
            check("R2/R3/R7 stream", detect_no_o, exp);
        end else begin
          check("R4/R6 non-final sample", detect_no_o, exp);
        end
      end
    end
  endtask

  task automatic push(logic [1:0] c);
    codes[ncodes] = c;
    ncodes++;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #3;
    check("R1 reset", detect_no_o, 1'b1);
    @(negedge clk_i);
    #2;
    check("R1 reset low phase", detect_no_o, 1'b1);
    rst_ni = 1'b1;

    // main stream: pad sample lands group 0 as {0,0,1}; groups 1..8 are the table
    ncodes = 0;
    push(C_SET);
    for (int p = 0; p < 8; p++)
      for (int b = 3; b >= 1; b--)
        push(VEC[p][b] ? C_SET : C_CLR);
    // R2 bounce groups: hold on open and on both closed
    push(C_SET); push(C_OPEN); push(C_BOTH);   // 1,1,1 odd
    push(C_CLR); push(C_OPEN); push(C_OPEN);   // 0,0,0 even
    push(C_SET); push(C_BOTH); push(C_CLR);    // 1,1,0 even
    run_stream(1, 8);

    // R1: reset mid-group discards the partial group
    @(posedge clk_i);
    #2;
    rst_ni = 1'b0;
    #1;
    check("R1 reset asserted", detect_no_o, 1'b1);
    @(negedge clk_i);
    #2;
    check("R1 reset low phase", detect_no_o, 1'b1);
    {throw_no_i, throw_nc_i} = C_CLR;
    @(negedge clk_i);
    #2;
    rst_ni = 1'b1;
    ncodes = 0;
    push(C_SET); push(C_SET); push(C_SET); push(C_CLR); push(C_SET);
    run_stream(99, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule